// File: doc/BRIEF.md
# Hybrid Phase Cell Redundant-State Selector

This block drives one phase of a hybrid multilevel cell. The cell has two two-level inverter legs, one on each end of an open winding. A capacitor-fed H-bridge sits in series with that winding. The phase voltage is built in quarter-bus steps. Each leg pair contributes twice the difference of its two top switches. The bridge contributes the difference of its two legs. The capacitor behind the bridge is meant to stay near one quarter of the bus voltage.

Each accepted command carries four things:
- a target level from -2 to +2, in quarter-bus units;
- the sign of the phase current;
- a flag saying the capacitor voltage is above its target;
- a flag saying the bridge is faulted.

The block turns the command into four registered gate signals and their inverses. Levels 0 and ±2 always bypass the capacitor. For ±1 the block picks between two redundant states: the bridge aiding the current or the bridge opposing it. It discharges the capacitor when that capacitor is high and charges it otherwise. When the bridge is faulted, the bridge legs are held off and the phase falls back to three-level operation.

Commands arrive as a valid/ready stream. The block never applies back-pressure: `cmd_ready` rises on the first clock after reset and stays high. A beat is taken on every clock edge where `cmd_valid` and `cmd_ready` are both high. The gate outputs change on the next edge and at no other time.

Top module: `phase_cell_selector`

## Requirements
- R1: While in reset and right after it, `gate` is 4'b0000, `gate_n` is 4'b1111 and `cmd_ready` is low during reset.
- R2: `gate_n` is always the bitwise inverse of `gate`.
- R3: `gate` changes only on the clock edge after an accepted beat; input changes without an accepted beat leave it unchanged.
- R4: Gate bit mapping is: bit 0 is the top switch of leg A, bit 1 is the top switch of leg B, bit 2 is bridge leg L and bit 3 is bridge leg R. The produced level is 2*(g0-g1)+(g2-g3). Level +2 gives 4'b0001, level -2 gives 4'b0010 and level 0 gives 4'b0000. The bridge legs are off for every even level.
- R5: For level ±1 with the capacitor-high flag set, the bridge conducts in the current's direction, which discharges the capacitor. Level +1 gives 4'b0100 for positive current and 4'b1001 for negative current. Level -1 gives 4'b0110 for positive current and 4'b1000 for negative current.
- R6: For level ±1 with the capacitor-high flag clear, the bridge opposes the current, which charges the capacitor. Level +1 gives 4'b1001 for positive current and 4'b0100 for negative current. Level -1 gives 4'b1000 for positive current and 4'b0110 for negative current.
- R7: With the bridge-fault flag set, bits 3:2 are 0. Levels ±2 and 0 behave as in R4, and levels ±1 give 4'b0000.
- R8: `cmd_level` is a two's-complement value. Any value outside -2..+2 (for the default width, -4, -3 and +3) gives 4'b0000.
- R9: For every in-range level that is not odd under fault, the produced level equals the commanded level.
- R10: Once out of reset, `cmd_ready` is high every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Command beat ready, high whenever out of reset |
| cmd_level | input | LVL_W | Target level, two's complement, quarter-bus units |
| cmd_i_pos | input | 1 | 1 when phase current flows from A to A' |
| cmd_cap_high | input | 1 | 1 when the capacitor is above its target |
| cmd_hb_fault | input | 1 | 1 when the bridge must be clamped off |
| gate | output | 4 | Switch gates {bridge R, bridge L, leg B top, leg A top} |
| gate_n | output | 4 | Inverse of `gate` |

## Verification
If the bridge polarity is chosen wrongly, the effect shows up as the wrong pair of bits 3:2 on the edge after a ±1 beat. A swap of charge and discharge flips those two bits and also moves one leg bit to keep the level. Every such error is visible one cycle after the offending command, and it stays visible until the next beat. A hold error shows as a gate change on a cycle with no accepted beat. The bench therefore mixes idle cycles that carry toggling inputs between beats.

// File: rtl/cellsel_pkg.sv
package cellsel_pkg;
  localparam int GATE_W   = 4;
  localparam int G_LEG_A  = 0;
  localparam int G_LEG_B  = 1;
  localparam int G_BR_L   = 2;
  localparam int G_BR_R   = 3;
  localparam int LVL_MAX  = 2;

  typedef enum logic [1:0] {BR_OFF = 2'd0, BR_POS = 2'd1, BR_NEG = 2'd2} br_mode_e;
  typedef enum logic [1:0] {LEG_OFF = 2'd0, LEG_POS = 2'd1, LEG_NEG = 2'd2} leg_mode_e;
endpackage

// File: rtl/cellsel_bridge_pick.sv
module cellsel_bridge_pick
  import cellsel_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic                    in_range,
  input  logic signed [LVL_W-1:0] level,
  input  logic                    i_pos,
  input  logic                    cap_high,
  input  logic                    hb_fault,
  output br_mode_e                br_mode
);
  logic odd_level;
  assign odd_level = level[0];

  // Aiding the current discharges the capacitor; opposing it charges.
  always_comb begin
    br_mode = BR_OFF;
    if (in_range && odd_level && !hb_fault) begin
      if (cap_high == i_pos) br_mode = BR_POS;
      else                   br_mode = BR_NEG;
    end
  end
endmodule

// File: rtl/cellsel_leg_pick.sv
module cellsel_leg_pick
  import cellsel_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic                    in_range,
  input  logic signed [LVL_W-1:0] level,
  input  br_mode_e                br_mode,
  output leg_mode_e               leg_mode
);
  localparam int REM_W = LVL_W + 1;

  logic signed [REM_W-1:0] br_val;
  logic signed [REM_W-1:0] rem;

  always_comb begin
    case (br_mode)
      BR_POS:  br_val = REM_W'(1);
      BR_NEG:  br_val = -REM_W'(1);
      default: br_val = '0;
    endcase
    rem = REM_W'(level) - br_val;
  end

  // Legs supply the remaining even part; an odd remainder (bridge held off) yields zero.
  always_comb begin
    leg_mode = LEG_OFF;
    if (in_range) begin
      if (rem == REM_W'(2))       leg_mode = LEG_POS;
      else if (rem == -REM_W'(2)) leg_mode = LEG_NEG;
    end
  end
endmodule

// File: rtl/cellsel_gate_bank.sv
module cellsel_gate_bank
  import cellsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  leg_mode_e         leg_mode,
  input  br_mode_e          br_mode,
  output logic [GATE_W-1:0] gate,
  output logic [GATE_W-1:0] gate_n
);
  logic [GATE_W-1:0] next_gate;

  always_comb begin
    next_gate          = '0;
    next_gate[G_LEG_A] = (leg_mode == LEG_POS);
    next_gate[G_LEG_B] = (leg_mode == LEG_NEG);
    next_gate[G_BR_L]  = (br_mode == BR_POS);
    next_gate[G_BR_R]  = (br_mode == BR_NEG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gate <= '0;
    else if (load) gate <= next_gate;
  end

  for (genvar k = 0; k < GATE_W; k++) begin : g_inv
    assign gate_n[k] = ~gate[k];
  end
endmodule

// File: rtl/phase_cell_selector.sv
module phase_cell_selector
  import cellsel_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [LVL_W-1:0] cmd_level,
  input  logic             cmd_i_pos,
  input  logic             cmd_cap_high,
  input  logic             cmd_hb_fault,
  output logic [3:0]       gate,
  output logic [3:0]       gate_n
);
  logic signed [LVL_W-1:0] lvl_s;
  logic                    in_range;
  logic                    accept;
  br_mode_e                br_mode;
  leg_mode_e               leg_mode;

  assign lvl_s    = $signed(cmd_level);
  assign in_range = (lvl_s <= LVL_W'(LVL_MAX)) && (lvl_s >= -LVL_W'(LVL_MAX));
  assign accept   = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_ready <= 1'b0;
    else        cmd_ready <= 1'b1;
  end

  cellsel_bridge_pick #(.LVL_W(LVL_W)) u_bridge (
    .in_range (in_range),
    .level    (lvl_s),
    .i_pos    (cmd_i_pos),
    .cap_high (cmd_cap_high),
    .hb_fault (cmd_hb_fault),
    .br_mode  (br_mode)
  );

  cellsel_leg_pick #(.LVL_W(LVL_W)) u_legs (
    .in_range (in_range),
    .level    (lvl_s),
    .br_mode  (br_mode),
    .leg_mode (leg_mode)
  );

  cellsel_gate_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .leg_mode (leg_mode),
    .br_mode  (br_mode),
    .gate     (gate),
    .gate_n   (gate_n)
  );
endmodule

// File: rtl/cellsel_chk.sv
module cellsel_chk #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [LVL_W-1:0] cmd_level,
  input logic             cmd_i_pos,
  input logic             cmd_cap_high,
  input logic             cmd_hb_fault,
  input logic [3:0]       gate,
  input logic [3:0]       gate_n
);
  logic                    seen, acc_q, ipos_q, hi_q, flt_q;
  logic signed [LVL_W-1:0] lvl_q;
  logic signed [3:0]       out_lvl;
  logic                    rng_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; acc_q <= 1'b0; ipos_q <= 1'b0; hi_q <= 1'b0; flt_q <= 1'b0; lvl_q <= '0;
    end else begin
      seen   <= 1'b1;
      acc_q  <= cmd_valid && cmd_ready;
      lvl_q  <= $signed(cmd_level);
      ipos_q <= cmd_i_pos;
      hi_q   <= cmd_cap_high;
      flt_q  <= cmd_hb_fault;
    end
  end

  always_comb begin
    out_lvl = 4'sd2 * ($signed({3'b000, gate[0]}) - $signed({3'b000, gate[1]}))
            + ($signed({3'b000, gate[2]}) - $signed({3'b000, gate[3]}));
    rng_q   = (lvl_q <= 2) && (lvl_q >= -2);
  end

  AST_GATE_INVERSE: assert property (@(posedge clk) gate_n == ~gate); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !acc_q |-> $stable(gate)); // R3
  AST_EVEN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    seen && acc_q && !lvl_q[0] |-> gate[3:2] == 2'b00); // R4
  AST_CAP_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    seen && acc_q && rng_q && lvl_q[0] && !flt_q |-> (gate[2] != gate[3]) && (gate[2] == (hi_q == ipos_q))); // R5
  AST_FAULT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    seen && acc_q && flt_q |-> gate[3:2] == 2'b00); // R7
  AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    seen && acc_q && !rng_q |-> gate == 4'b0000); // R8
  AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    seen && acc_q && rng_q && !(flt_q && lvl_q[0]) |-> out_lvl == 4'(lvl_q)); // R9
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> cmd_ready); // R10
endmodule

bind phase_cell_selector cellsel_chk #(.LVL_W(LVL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_level    (cmd_level),
  .cmd_i_pos    (cmd_i_pos),
  .cmd_cap_high (cmd_cap_high),
  .cmd_hb_fault (cmd_hb_fault),
  .gate         (gate),
  .gate_n       (gate_n)
);

// File: tb/phase_cell_selector_bench.sv
module phase_cell_selector_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_level = 3'd0;
  logic       cmd_i_pos = 1'b0;
  logic       cmd_cap_high = 1'b0;
  logic       cmd_hb_fault = 1'b0;
  logic [3:0] gate, gate_n;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit pend = 1'b0;
  bit done = 1'b0;
  logic [3:0] expq[$];
  string      tagq[$];

  always #2 clk = ~clk;

  phase_cell_selector u_phase_cell_selector (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_level(cmd_level), .cmd_i_pos(cmd_i_pos), .cmd_cap_high(cmd_cap_high),
    .cmd_hb_fault(cmd_hb_fault), .gate(gate), .gate_n(gate_n)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input int lvl, input bit ip, input bit hi, input bit flt);
    case (lvl)
      2:  return 4'b0001;
      -2: return 4'b0010;
      1:  return flt ? 4'b0000 : ((hi == ip) ? 4'b0100 : 4'b1001);
      -1: return flt ? 4'b0000 : ((hi == ip) ? 4'b0110 : 4'b1000);
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string req_of(input int lvl, input bit hi, input bit flt);
    if (lvl > 2 || lvl < -2) return "R8";
    if (flt) return "R7";
    if (lvl == 1 || lvl == -1) return hi ? "R5" : "R6";
    return "R4";
  endfunction

  task automatic send(input int lvl, input bit ip, input bit hi, input bit flt);
    @(negedge clk);
    cmd_level = 3'(lvl); cmd_i_pos = ip; cmd_cap_high = hi; cmd_hb_fault = flt;
    cmd_valid = 1'b1;
    expq.push_back(model(lvl, ip, hi, flt));
    tagq.push_back(req_of(lvl, hi, flt));
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cmd_valid && cmd_ready) pend = 1'b1;
  end

  always @(negedge clk) begin
    if (pend) begin
      logic [3:0] e;
      string      t;
      pend = 1'b0;
      e = expq.pop_front();
      t = tagq.pop_front();
      check(t, gate, e);
      check("R9", gate, e);
      check("R2", gate_n, ~gate);
    end
  end

  initial begin
    logic [3:0] held;
    #1;
    check("R1", gate, 4'b0000);
    check("R1", gate_n, 4'b1111);
    check("R1", {3'b000, cmd_ready}, 4'b0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {3'b000, cmd_ready}, 4'b0001);
    check("R1", gate, 4'b0000);
    for (int f = 0; f < 2; f++)
      for (int h = 0; h < 2; h++)
        for (int i = 0; i < 2; i++)
          for (int l = -4; l < 4; l++)
            send(l, i[0], h[0], f[0]);
    // R3: idle cycles with toggling inputs must not move the gates
    send(1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    held = gate;
    for (int k = 0; k < 4; k++) begin
      cmd_level = 3'(k - 2); cmd_i_pos = ~cmd_i_pos; cmd_cap_high = k[0];
      @(negedge clk);
      check("R3", gate, held);
    end
    // back-to-back beats
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_level = 3'd2; expq.push_back(4'b0001); tagq.push_back("R4");
    @(negedge clk);
    cmd_level = 3'b111; cmd_i_pos = 1'b0; cmd_cap_high = 1'b0; cmd_hb_fault = 1'b0;
    expq.push_back(4'b0110); tagq.push_back("R6");
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", {3'b000, cmd_ready}, 4'b0001);
    check("R3", {3'b000, expq.size() == 0}, 4'b0001);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cycles > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule